// File: doc/BRIEF.md
# Register Writer-Order Dependency Tracker

This block sits beside the issue logic of an in-order pipeline and records, for every architectural register, which in-flight instructions are still going to write it. Each register owns a short queue of writer sequence numbers kept oldest-first. The integer, floating-point and miscellaneous register classes each have their own index space, and the three are tracked separately. The pipeline appends a writer when it issues an instruction. An instruction with several destinations issues one append per destination. The writer leaves the queue either by a search-and-delete on its sequence number or by popping it from the head once it retires. A further port records that a writer has executed, which makes its result eligible for forwarding.

Three combinational queries answer the questions that issue and writeback ask. Read permission and write permission are both granted when the queue is empty or when the requester is not younger than the oldest pending writer. The forwarding query returns the youngest writer that is older than the requester. It reports that writer as usable only when its execution was recorded on an earlier cycle. Misuse is reported on three registered error pulses: an append to a full queue, a search-and-delete that finds nothing, and a head pop that does not match.

Top module: `reg_dep_tracker`

## Requirements
- R1: After reset every queue is empty. Every read or write query is granted, no forward source is reported, and all error outputs are 0.
- R2: An append places the writer's sequence number at the tail of the selected register's queue. The queue therefore holds writers in append order.
- R3: A read query is granted when the selected queue is empty or when the requester's sequence number is less than or equal to the head entry. It is refused otherwise.
- R4: A write query follows the same rule as R3, evaluated on its own register and sequence number inputs.
- R5: The forward query scans from the head and selects the last entry whose sequence number is strictly below the requester's. The scan stops at the first entry that is not. `fwdHit` shows whether such an entry exists and `fwdSrcSeq` gives its number. `fwdValid` is 1 only if that entry's execution was recorded in an earlier cycle, so a mark applied in the current cycle is not yet visible.
- R6: A search-and-delete removes only the matching entry and closes the gap. When no entry matches, the queue is unchanged and `errNoMatch` is 1 in the cycle after the request.
- R7: A head pop removes the oldest entry when it carries the given sequence number. When the queue is empty or the head differs, the queue is unchanged and `errHeadMismatch` is 1 in the cycle after the request.
- R8: Append, delete, pop and execute-mark requests aimed at integer register 0 are ignored and raise no error. Register 0 of the other classes is tracked normally.
- R9: Class codes are 0 = integer, 1 = floating-point and 2 = miscellaneous. A request to one class never changes the queues of another class that has the same index.
- R10: An append to a queue holding DEPTH entries is dropped and `errOverflow` is 1 in the cycle after the request.
- R11: Requests that reach the same register in one cycle are applied in a fixed order: pop, then search-and-delete, then execute-mark, then append. A pop and an append together on a full queue therefore succeed without overflow.
- R12: A flush empties every queue at the next clock edge, and error pulses for that cycle are suppressed.
- R13: A request with class code 3, or with an index at or above its class's register count, is ignored and raises no error. A query with such a class or index reports an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all queues |
| insValid | input | 1 | Append request |
| insClass | input | 2 | Register class for append |
| insIdx | input | IDX_W | Register index for append |
| insSeq | input | SEQ_W | Sequence number to append |
| rmValid | input | 1 | Search-and-delete request |
| rmClass | input | 2 | Register class for delete |
| rmIdx | input | IDX_W | Register index for delete |
| rmSeq | input | SEQ_W | Sequence number to delete |
| popValid | input | 1 | Head pop request |
| popClass | input | 2 | Register class for pop |
| popIdx | input | IDX_W | Register index for pop |
| popSeq | input | SEQ_W | Expected head sequence number |
| doneValid | input | 1 | Execute-mark request |
| doneClass | input | 2 | Register class for mark |
| doneIdx | input | IDX_W | Register index for mark |
| doneSeq | input | SEQ_W | Sequence number whose result is ready |
| rdClass | input | 2 | Read query class |
| rdIdx | input | IDX_W | Read query index |
| rdSeq | input | SEQ_W | Read requester sequence number |
| rdOk | output | 1 | Read permitted |
| wrClass | input | 2 | Write query class |
| wrIdx | input | IDX_W | Write query index |
| wrSeq | input | SEQ_W | Write requester sequence number |
| wrOk | output | 1 | Write permitted |
| fwdClass | input | 2 | Forward query class |
| fwdIdx | input | IDX_W | Forward query index |
| fwdSeq | input | SEQ_W | Forward requester sequence number |
| fwdHit | output | 1 | An older writer exists |
| fwdValid | output | 1 | That writer's result is usable |
| fwdSrcSeq | output | SEQ_W | Sequence number of the selected writer |
| errOverflow | output | 1 | Append dropped on a full queue |
| errNoMatch | output | 1 | Search-and-delete found nothing |
| errHeadMismatch | output | 1 | Head pop failed |

## Verification
The bench builds a three-deep queue and probes forwarding just above, between and below its entries. A design that chose the oldest older writer, or used less-or-equal, would return the wrong source. It applies an execute mark and queries in the same cycle, which catches a design that forwards a result before the following edge. It deletes a middle entry, misses on a delete, pops with a wrong head and pops an empty queue. A design that shifted the wrong slots, or altered the queue on a failed request, would show a different head or source afterwards. It also drives integer register 0, an invalid class, an out-of-range index, an overflow, a simultaneous pop and append on a full queue, and a flush. These catch a design that leaks across classes, counts an append before its removal, or leaves entries behind.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  localparam logic [1:0] CLS_INT  = 2'd0;
  localparam logic [1:0] CLS_FP   = 2'd1;
  localparam logic [1:0] CLS_MISC = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic ins;
    logic rm;
    logic pop;
    logic done;
    logic rdIn;
    logic wrIn;
    logic fwdIn;
  } ctrlStb_t;
endpackage

// File: rtl/rdt_ctrl.sv
module rdt_ctrl
  import rdt_pkg::*;
#(
  parameter int NUM_INT  = 8,
  parameter int NUM_FP   = 8,
  parameter int NUM_MISC = 4,
  parameter int IDX_W    = 3,
  parameter int FLAT_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [1:0]        insClass,
  input  logic [IDX_W-1:0]  insIdx,
  input  logic              rmValid,
  input  logic [1:0]        rmClass,
  input  logic [IDX_W-1:0]  rmIdx,
  input  logic              popValid,
  input  logic [1:0]        popClass,
  input  logic [IDX_W-1:0]  popIdx,
  input  logic              doneValid,
  input  logic [1:0]        doneClass,
  input  logic [IDX_W-1:0]  doneIdx,
  input  logic [1:0]        rdClass,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [1:0]        wrClass,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        fwdClass,
  input  logic [IDX_W-1:0]  fwdIdx,
  output ctrlStb_t          stb,
  output logic [FLAT_W-1:0] insFlat,
  output logic [FLAT_W-1:0] rmFlat,
  output logic [FLAT_W-1:0] popFlat,
  output logic [FLAT_W-1:0] doneFlat,
  output logic [FLAT_W-1:0] rdFlat,
  output logic [FLAT_W-1:0] wrFlat,
  output logic [FLAT_W-1:0] fwdFlat
);
  localparam int FP_BASE   = NUM_INT;
  localparam int MISC_BASE = NUM_INT + NUM_FP;

  // returns {inRange, flatIndex}
  function automatic logic [FLAT_W:0] mapFlat(input logic [1:0] cls,
                                                input logic [IDX_W-1:0] idx);
    logic [FLAT_W:0] res;
    int           idxI;
    res  = '0;
    idxI = int'(idx);
    case (cls)
      CLS_INT:  if (idxI < NUM_INT)  res = {1'b1, FLAT_W'(idxI)};
      CLS_FP:   if (idxI < NUM_FP)   res = {1'b1, FLAT_W'(idxI + FP_BASE)};
      CLS_MISC: if (idxI < NUM_MISC) res = {1'b1, FLAT_W'(idxI + MISC_BASE)};
      default:  res = '0;
    endcase
    return res;
  endfunction

  function automatic logic isZeroReg(input logic [1:0] cls, input logic [IDX_W-1:0] idx);
    return (cls == CLS_INT) && (idx == '0);
  endfunction

  logic [FLAT_W:0] insMap, rmMap, popMap, doneMap, rdMap, wrMap, fwdMap;

  always_comb begin
    insMap  = mapFlat(insClass, insIdx);
    rmMap   = mapFlat(rmClass, rmIdx);
    popMap  = mapFlat(popClass, popIdx);
    doneMap = mapFlat(doneClass, doneIdx);
    rdMap   = mapFlat(rdClass, rdIdx);
    wrMap   = mapFlat(wrClass, wrIdx);
    fwdMap  = mapFlat(fwdClass, fwdIdx);

    stb.ins   = insValid  && insMap[FLAT_W]  && !isZeroReg(insClass, insIdx);
    stb.rm    = rmValid   && rmMap[FLAT_W]   && !isZeroReg(rmClass, rmIdx);
    stb.pop   = popValid  && popMap[FLAT_W]  && !isZeroReg(popClass, popIdx);
    stb.done  = doneValid && doneMap[FLAT_W] && !isZeroReg(doneClass, doneIdx);
    stb.rdIn  = rdMap[FLAT_W];
    stb.wrIn  = wrMap[FLAT_W];
    stb.fwdIn = fwdMap[FLAT_W];

    insFlat  = insMap[FLAT_W-1:0];
    rmFlat   = rmMap[FLAT_W-1:0];
    popFlat  = popMap[FLAT_W-1:0];
    doneFlat = doneMap[FLAT_W-1:0];
    rdFlat   = rdMap[FLAT_W-1:0];
    wrFlat   = wrMap[FLAT_W-1:0];
    fwdFlat  = fwdMap[FLAT_W-1:0];
  end

  // R8: integer register 0 never reaches a queue
  a_r8_zero_reg_skipped: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && insClass == CLS_INT && insIdx == '0) |-> !stb.ins);

  // R13: class code 3 never reaches a queue
  a_r13_bad_class_skipped: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && insClass == 2'd3) |-> !stb.ins);
endmodule

// File: rtl/rdt_regq.sv
module rdt_regq #(
  parameter int SEQ_W = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flush,
  input  logic                        insEn,
  input  logic [SEQ_W-1:0]            insSeq,
  input  logic                        rmEn,
  input  logic [SEQ_W-1:0]            rmSeq,
  input  logic                        popEn,
  input  logic [SEQ_W-1:0]            popSeq,
  input  logic                        doneEn,
  input  logic [SEQ_W-1:0]            doneSeq,
  output logic [DEPTH-1:0][SEQ_W-1:0] seqQ,
  output logic [DEPTH-1:0]            doneQ,
  output logic [CNT_W-1:0]            cntQ,
  output logic                        errOvf,
  output logic                        errMiss,
  output logic                        errHead
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DEPTH-1:0][SEQ_W-1:0] seqN;
  logic [DEPTH-1:0]            doneN;
  logic [CNT_W-1:0]            cntN;
  logic                        rmHit;
  int                          rmPos;
  logic                        ovfRaw, missRaw, headRaw;

  always_comb begin
    seqN    = seqQ;
    doneN   = doneQ;
    cntN    = cntQ;
    rmHit   = 1'b0;
    rmPos   = 0;
    ovfRaw  = 1'b0;
    missRaw = 1'b0;
    headRaw = 1'b0;

    // step 1: head pop
    if (popEn) begin
      if (cntN == '0 || seqN[0] != popSeq) begin
        headRaw = 1'b1;
      end else begin
        for (int k = 0; k < DEPTH - 1; k++) begin
          seqN[k]  = seqN[k+1];
          doneN[k] = doneN[k+1];
        end
        seqN[DEPTH-1]  = '0;
        doneN[DEPTH-1] = 1'b0;
        cntN           = cntN - 1'b1;
      end
    end

    // step 2: search and delete
    if (rmEn) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (!rmHit && CNT_W'(k) < cntN && seqN[k] == rmSeq) begin
          rmHit = 1'b1;
          rmPos = k;
        end
      end
      if (rmHit) begin
        for (int k = 0; k < DEPTH - 1; k++) begin
          if (k >= rmPos) begin
            seqN[k]  = seqN[k+1];
            doneN[k] = doneN[k+1];
          end
        end
        seqN[DEPTH-1]  = '0;
        doneN[DEPTH-1] = 1'b0;
        cntN           = cntN - 1'b1;
      end else begin
        missRaw = 1'b1;
      end
    end

    // step 3: execute mark
    if (doneEn) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (CNT_W'(k) < cntN && seqN[k] == doneSeq) doneN[k] = 1'b1;
      end
    end

    // step 4: append at tail
    if (insEn) begin
      if (cntN == FULL) begin
        ovfRaw = 1'b1;
      end else begin
        for (int k = 0; k < DEPTH; k++) begin
          if (CNT_W'(k) == cntN) begin
            seqN[k]  = insSeq;
            doneN[k] = 1'b0;
          end
        end
        cntN = cntN + 1'b1;
      end
    end
  end

  assign errOvf  = ovfRaw  && !flush;
  assign errMiss = missRaw && !flush;
  assign errHead = headRaw && !flush;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqQ  <= '0;
      doneQ <= '0;
      cntQ  <= '0;
    end else if (flush) begin
      doneQ <= '0;
      cntQ  <= '0;
    end else begin
      seqQ  <= seqN;
      doneQ <= doneN;
      cntQ  <= cntN;
    end
  end

  // R2: a lone append grows the queue by one and lands at the old tail
  a_r2_append_tail: assert property (@(posedge clk) disable iff (!rstN)
    (insEn && !popEn && !rmEn && !flush && cntQ != FULL)
      |=> (cntQ == CNT_W'($past(cntQ) + 1'b1)));

  // R10: a lone append on a full queue leaves it full
  a_r10_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (insEn && !popEn && !rmEn && !flush && cntQ == FULL) |=> (cntQ == FULL));

  // R7: a matching lone pop shrinks the queue by one
  a_r7_pop_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !rmEn && !insEn && !flush && cntQ != '0 && seqQ[0] == popSeq)
      |=> (cntQ == CNT_W'($past(cntQ) - 1'b1)));

  // R12: flush empties the queue
  a_r12_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (cntQ == '0));

  // R10: occupancy never exceeds the depth
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= FULL);
endmodule

// File: rtl/rdt_dpath.sv
module rdt_dpath
  import rdt_pkg::*;
#(
  parameter int NREG   = 20,
  parameter int FLAT_W = 5,
  parameter int SEQ_W  = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  ctrlStb_t          stb,
  input  logic [FLAT_W-1:0] insFlat,
  input  logic [FLAT_W-1:0] rmFlat,
  input  logic [FLAT_W-1:0] popFlat,
  input  logic [FLAT_W-1:0] doneFlat,
  input  logic [FLAT_W-1:0] rdFlat,
  input  logic [FLAT_W-1:0] wrFlat,
  input  logic [FLAT_W-1:0] fwdFlat,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic [SEQ_W-1:0]  rmSeq,
  input  logic [SEQ_W-1:0]  popSeq,
  input  logic [SEQ_W-1:0]  doneSeq,
  input  logic [SEQ_W-1:0]  rdSeq,
  input  logic [SEQ_W-1:0]  wrSeq,
  input  logic [SEQ_W-1:0]  fwdSeq,
  output logic              rdOk,
  output logic              wrOk,
  output logic              fwdHit,
  output logic              fwdValid,
  output logic [SEQ_W-1:0]  fwdSrcSeq,
  output logic              errOverflow,
  output logic              errNoMatch,
  output logic              errHeadMismatch
);
  logic [DEPTH-1:0][SEQ_W-1:0] seqAll  [NREG];
  logic [DEPTH-1:0]            doneAll [NREG];
  logic [CNT_W-1:0]            cntAll  [NREG];
  logic [NREG-1:0]             ovfVec, missVec, headVec;

  for (genvar r = 0; r < NREG; r++) begin : gQueue
    rdt_regq #(.SEQ_W(SEQ_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uQueue (
      .clk     (clk),
      .rstN    (rstN),
      .flush   (flush),
      .insEn   (stb.ins  && insFlat  == FLAT_W'(r)),
      .insSeq  (insSeq),
      .rmEn    (stb.rm   && rmFlat   == FLAT_W'(r)),
      .rmSeq   (rmSeq),
      .popEn   (stb.pop  && popFlat  == FLAT_W'(r)),
      .popSeq  (popSeq),
      .doneEn  (stb.done && doneFlat == FLAT_W'(r)),
      .doneSeq (doneSeq),
      .seqQ    (seqAll[r]),
      .doneQ   (doneAll[r]),
      .cntQ    (cntAll[r]),
      .errOvf  (ovfVec[r]),
      .errMiss (missVec[r]),
      .errHead (headVec[r])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errOverflow     <= 1'b0;
      errNoMatch      <= 1'b0;
      errHeadMismatch <= 1'b0;
    end else begin
      errOverflow     <= |ovfVec;
      errNoMatch      <= |missVec;
      errHeadMismatch <= |headVec;
    end
  end

  // permission queries: empty queue or requester not younger than head
  always_comb begin
    rdOk = 1'b1;
    if (stb.rdIn && cntAll[rdFlat] != '0) rdOk = (rdSeq <= seqAll[rdFlat][0]);
    wrOk = 1'b1;
    if (stb.wrIn && cntAll[wrFlat] != '0) wrOk = (wrSeq <= seqAll[wrFlat][0]);
  end

  // forwarding: youngest writer older than the requester
  logic [DEPTH-1:0][SEQ_W-1:0] fwdQ;
  logic [DEPTH-1:0]            fwdDone;
  logic [CNT_W-1:0]            fwdCnt;
  logic                        scanStop;
  int                          fwdSel;

  always_comb begin
    fwdQ     = seqAll[fwdFlat];
    fwdDone  = doneAll[fwdFlat];
    fwdCnt   = stb.fwdIn ? cntAll[fwdFlat] : '0;
    fwdHit   = 1'b0;
    fwdSel   = 0;
    scanStop = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!scanStop && CNT_W'(k) < fwdCnt && fwdQ[k] < fwdSeq) begin
        fwdHit = 1'b1;
        fwdSel = k;
      end else begin
        scanStop = 1'b1;
      end
    end
    fwdSrcSeq = fwdHit ? fwdQ[fwdSel] : '0;
    fwdValid  = fwdHit && fwdDone[fwdSel];
  end

  // R5: a usable source is always an older writer
  a_r5_valid_source_older: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (fwdHit && fwdSrcSeq < fwdSeq));

  // R12: no error pulse follows a flush cycle
  a_r12_flush_quiet: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !(errOverflow || errNoMatch || errHeadMismatch));
endmodule

// File: rtl/reg_dep_tracker.sv
module reg_dep_tracker
  import rdt_pkg::*;
#(
  parameter int NUM_INT  = 8,
  parameter int NUM_FP   = 8,
  parameter int NUM_MISC = 4,
  parameter int IDX_W    = 3,
  parameter int SEQ_W    = 8,
  parameter int DEPTH    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             insValid,
  input  logic [1:0]       insClass,
  input  logic [IDX_W-1:0] insIdx,
  input  logic [SEQ_W-1:0] insSeq,
  input  logic             rmValid,
  input  logic [1:0]       rmClass,
  input  logic [IDX_W-1:0] rmIdx,
  input  logic [SEQ_W-1:0] rmSeq,
  input  logic             popValid,
  input  logic [1:0]       popClass,
  input  logic [IDX_W-1:0] popIdx,
  input  logic [SEQ_W-1:0] popSeq,
  input  logic             doneValid,
  input  logic [1:0]       doneClass,
  input  logic [IDX_W-1:0] doneIdx,
  input  logic [SEQ_W-1:0] doneSeq,
  input  logic [1:0]       rdClass,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [SEQ_W-1:0] rdSeq,
  output logic             rdOk,
  input  logic [1:0]       wrClass,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [SEQ_W-1:0] wrSeq,
  output logic             wrOk,
  input  logic [1:0]       fwdClass,
  input  logic [IDX_W-1:0] fwdIdx,
  input  logic [SEQ_W-1:0] fwdSeq,
  output logic             fwdHit,
  output logic             fwdValid,
  output logic [SEQ_W-1:0] fwdSrcSeq,
  output logic             errOverflow,
  output logic             errNoMatch,
  output logic             errHeadMismatch
);
  localparam int NREG   = NUM_INT + NUM_FP + NUM_MISC;
  localparam int FLAT_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  ctrlStb_t          stb;
  logic [FLAT_W-1:0] insFlat, rmFlat, popFlat, doneFlat, rdFlat, wrFlat, fwdFlat;

  rdt_ctrl #(
    .NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .NUM_MISC(NUM_MISC),
    .IDX_W(IDX_W), .FLAT_W(FLAT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .insClass(insClass), .insIdx(insIdx),
    .rmValid(rmValid), .rmClass(rmClass), .rmIdx(rmIdx),
    .popValid(popValid), .popClass(popClass), .popIdx(popIdx),
    .doneValid(doneValid), .doneClass(doneClass), .doneIdx(doneIdx),
    .rdClass(rdClass), .rdIdx(rdIdx),
    .wrClass(wrClass), .wrIdx(wrIdx),
    .fwdClass(fwdClass), .fwdIdx(fwdIdx),
    .stb(stb),
    .insFlat(insFlat), .rmFlat(rmFlat), .popFlat(popFlat), .doneFlat(doneFlat),
    .rdFlat(rdFlat), .wrFlat(wrFlat), .fwdFlat(fwdFlat)
  );

  rdt_dpath #(
    .NREG(NREG), .FLAT_W(FLAT_W), .SEQ_W(SEQ_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .flush(flush), .stb(stb),
    .insFlat(insFlat), .rmFlat(rmFlat), .popFlat(popFlat), .doneFlat(doneFlat),
    .rdFlat(rdFlat), .wrFlat(wrFlat), .fwdFlat(fwdFlat),
    .insSeq(insSeq), .rmSeq(rmSeq), .popSeq(popSeq), .doneSeq(doneSeq),
    .rdSeq(rdSeq), .wrSeq(wrSeq), .fwdSeq(fwdSeq),
    .rdOk(rdOk), .wrOk(wrOk),
    .fwdHit(fwdHit), .fwdValid(fwdValid), .fwdSrcSeq(fwdSrcSeq),
    .errOverflow(errOverflow), .errNoMatch(errNoMatch),
    .errHeadMismatch(errHeadMismatch)
  );
endmodule

// File: tb/tb_reg_dep_tracker.sv
module tb_reg_dep_tracker;
  localparam int IDX_W = 3;
  localparam int SEQ_W = 8;
  localparam logic [1:0] CI = 2'd0, CF = 2'd1, CM = 2'd2, CX = 2'd3;

  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0;
  logic insValid = 0, rmValid = 0, popValid = 0, doneValid = 0;
  logic [1:0] insClass = 0, rmClass = 0, popClass = 0, doneClass = 0;
  logic [1:0] rdClass = 0, wrClass = 0, fwdClass = 0;
  logic [IDX_W-1:0] insIdx = 0, rmIdx = 0, popIdx = 0, doneIdx = 0;
  logic [IDX_W-1:0] rdIdx = 0, wrIdx = 0, fwdIdx = 0;
  logic [SEQ_W-1:0] insSeq = 0, rmSeq = 0, popSeq = 0, doneSeq = 0;
  logic [SEQ_W-1:0] rdSeq = 0, wrSeq = 0, fwdSeq = 0;
  logic rdOk, wrOk, fwdHit, fwdValid, errOverflow, errNoMatch, errHeadMismatch;
  logic [SEQ_W-1:0] fwdSrcSeq;

  int errCnt = 0, chkCnt = 0;

  always #10 clk = ~clk;

  reg_dep_tracker dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .insValid(insValid), .insClass(insClass), .insIdx(insIdx), .insSeq(insSeq),
    .rmValid(rmValid), .rmClass(rmClass), .rmIdx(rmIdx), .rmSeq(rmSeq),
    .popValid(popValid), .popClass(popClass), .popIdx(popIdx), .popSeq(popSeq),
    .doneValid(doneValid), .doneClass(doneClass), .doneIdx(doneIdx), .doneSeq(doneSeq),
    .rdClass(rdClass), .rdIdx(rdIdx), .rdSeq(rdSeq), .rdOk(rdOk),
    .wrClass(wrClass), .wrIdx(wrIdx), .wrSeq(wrSeq), .wrOk(wrOk),
    .fwdClass(fwdClass), .fwdIdx(fwdIdx), .fwdSeq(fwdSeq),
    .fwdHit(fwdHit), .fwdValid(fwdValid), .fwdSrcSeq(fwdSrcSeq),
    .errOverflow(errOverflow), .errNoMatch(errNoMatch), .errHeadMismatch(errHeadMismatch)
  );

  task automatic chk(input string req, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 append, 1 delete, 2 pop, 3 mark; errors visible on return
  task automatic doOp(input int kind, input logic [1:0] c, input int i, input int s);
    @(negedge clk);
    case (kind)
      0: begin insValid = 1; insClass = c; insIdx = IDX_W'(i); insSeq = SEQ_W'(s); end
      1: begin rmValid = 1; rmClass = c; rmIdx = IDX_W'(i); rmSeq = SEQ_W'(s); end
      2: begin popValid = 1; popClass = c; popIdx = IDX_W'(i); popSeq = SEQ_W'(s); end
      default: begin doneValid = 1; doneClass = c; doneIdx = IDX_W'(i); doneSeq = SEQ_W'(s); end
    endcase
    @(negedge clk);
    insValid = 0; rmValid = 0; popValid = 0; doneValid = 0;
    #1;
  endtask

  task automatic qRd(input logic [1:0] c, input int i, input int s);
    rdClass = c; rdIdx = IDX_W'(i); rdSeq = SEQ_W'(s); #1;
  endtask
  task automatic qWr(input logic [1:0] c, input int i, input int s);
    wrClass = c; wrIdx = IDX_W'(i); wrSeq = SEQ_W'(s); #1;
  endtask
  task automatic qFwd(input logic [1:0] c, input int i, input int s);
    fwdClass = c; fwdIdx = IDX_W'(i); fwdSeq = SEQ_W'(s); #1;
  endtask

  task automatic tReset();
    qRd(CI, 3, 0);    chk("R1 rdOk", rdOk, 1);
    qWr(CF, 2, 0);    chk("R1 wrOk", wrOk, 1);
    qFwd(CM, 1, 255); chk("R1 fwdHit", fwdHit, 0);
    chk("R1 errors", {errOverflow, errNoMatch, errHeadMismatch}, 0);
  endtask

  task automatic tReadWrite();
    doOp(0, CI, 3, 10); doOp(0, CI, 3, 20); doOp(0, CI, 3, 30);
    qRd(CI, 3, 10); chk("R3 equal head", rdOk, 1);
    qRd(CI, 3, 5);  chk("R3 older", rdOk, 1);
    qRd(CI, 3, 11); chk("R3 younger", rdOk, 0);
    qRd(CI, 4, 99); chk("R3 empty", rdOk, 1);
    qWr(CI, 3, 11); chk("R4 younger", wrOk, 0);
    qWr(CI, 3, 10); chk("R4 equal head", wrOk, 1);
  endtask

  task automatic tForward();
    qFwd(CI, 3, 25); chk("R2 hit", fwdHit, 1); chk("R2 src middle", fwdSrcSeq, 20);
    chk("R5 not executed", fwdValid, 0);
    qFwd(CI, 3, 35); chk("R2 src tail", fwdSrcSeq, 30);
    qFwd(CI, 3, 10); chk("R5 equal not older", fwdHit, 0);
    qFwd(CI, 3, 5);  chk("R5 none older", fwdHit, 0);
  endtask

  task automatic tExecMark();
    @(negedge clk);
    doneValid = 1; doneClass = CI; doneIdx = 3; doneSeq = 20;
    qFwd(CI, 3, 25); chk("R5 same-cycle mark", fwdValid, 0);
    @(negedge clk);
    doneValid = 0; #1;
    chk("R5 marked earlier", fwdValid, 1);
    qFwd(CI, 3, 35); chk("R5 other entry unmarked", fwdValid, 0);
  endtask

  task automatic tMatch();
    doOp(1, CI, 3, 20); chk("R6 hit no error", errNoMatch, 0);
    qFwd(CI, 3, 25); chk("R6 gap closed", fwdSrcSeq, 10);
    qFwd(CI, 3, 35); chk("R6 tail kept", fwdSrcSeq, 30);
    doOp(1, CI, 3, 77); chk("R6 miss flag", errNoMatch, 1);
    qFwd(CI, 3, 35); chk("R6 miss unchanged", fwdSrcSeq, 30);
  endtask

  task automatic tHead();
    doOp(2, CI, 3, 30); chk("R7 wrong head flag", errHeadMismatch, 1);
    qRd(CI, 3, 11); chk("R7 wrong head unchanged", rdOk, 0);
    doOp(2, CI, 3, 10); chk("R7 good pop", errHeadMismatch, 0);
    qRd(CI, 3, 30); chk("R7 new head", rdOk, 1);
    qRd(CI, 3, 31); chk("R7 new head younger", rdOk, 0);
    doOp(2, CI, 3, 30);
    doOp(2, CI, 3, 30); chk("R7 empty pop flag", errHeadMismatch, 1);
    qRd(CI, 3, 200); chk("R7 emptied", rdOk, 1);
  endtask

  task automatic tZero();
    doOp(0, CI, 0, 1);
    qRd(CI, 0, 200); chk("R8 int0 not tracked", rdOk, 1);
    qFwd(CI, 0, 200); chk("R8 int0 no source", fwdHit, 0);
    doOp(1, CI, 0, 99); chk("R8 delete ignored", errNoMatch, 0);
    doOp(2, CI, 0, 5);  chk("R8 pop ignored", errHeadMismatch, 0);
    doOp(0, CF, 0, 5);
    qRd(CF, 0, 6); chk("R8 fp0 tracked", rdOk, 0);
    doOp(2, CF, 0, 5);
  endtask

  task automatic tClass();
    doOp(0, CI, 2, 40);
    qRd(CF, 2, 41); chk("R9 fp isolated", rdOk, 1);
    qRd(CM, 2, 41); chk("R9 misc isolated", rdOk, 1);
    qRd(CI, 2, 41); chk("R9 int tracked", rdOk, 0);
    qFwd(CF, 2, 50); chk("R9 fp no source", fwdHit, 0);
  endtask

  task automatic tOverflow();
    for (int s = 1; s <= 4; s++) begin
      doOp(0, CM, 1, s); chk("R10 fill no flag", errOverflow, 0);
    end
    doOp(0, CM, 1, 5); chk("R10 overflow flag", errOverflow, 1);
    qFwd(CM, 1, 200); chk("R10 dropped", fwdSrcSeq, 4);
  endtask

  task automatic tSameCycle();
    @(negedge clk);
    popValid = 1; popClass = CM; popIdx = 1; popSeq = 1;
    insValid = 1; insClass = CM; insIdx = 1; insSeq = 6;
    @(negedge clk);
    popValid = 0; insValid = 0; #1;
    chk("R11 no overflow", errOverflow, 0);
    chk("R11 pop ok", errHeadMismatch, 0);
    qFwd(CM, 1, 200); chk("R11 appended", fwdSrcSeq, 6);
    qFwd(CM, 1, 3);   chk("R11 head advanced", fwdSrcSeq, 2);
  endtask

  task automatic tBadIndex();
    doOp(0, CX, 1, 9);
    chk("R13 bad class no error", errOverflow, 0);
    qRd(CI, 1, 10); chk("R13 int1 untouched", rdOk, 1);
    qRd(CF, 1, 10); chk("R13 fp1 untouched", rdOk, 1);
    doOp(0, CM, 5, 9);
    chk("R13 bad index no error", errOverflow, 0);
    qRd(CM, 5, 0); chk("R13 bad index query empty", rdOk, 1);
    qFwd(CM, 1, 200); chk("R13 misc1 untouched", fwdSrcSeq, 6);
  endtask

  task automatic tFlush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0; #1;
    qRd(CI, 2, 41); chk("R12 int2 emptied", rdOk, 1);
    qFwd(CM, 1, 200); chk("R12 misc1 emptied", fwdHit, 0);
    doOp(2, CM, 1, 2); chk("R12 pop after flush", errHeadMismatch, 1);
  endtask

  initial begin
    #2000000;
    errCnt++; chkCnt++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    tReset();
    tReadWrite();
    tForward();
    tExecMark();
    tMatch();
    tHead();
    tZero();
    tClass();
    tOverflow();
    tSameCycle();
    tBadIndex();
    tFlush();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule